// File: doc/BRIEF.md
# Twin-Port Byte RAM with Collision Arbitration

A clocked memory of 2048 bytes shared by two independent ports, left and right. Each port has an active-low enable, a write select (low means write), an active-low output enable, an 11-bit address and 8-bit write data. Each port gets back registered read data, a read-valid flag and an active-low busy flag. All port inputs are sampled on the rising clock edge. Read data, read-valid and busy are registered and show the result of that edge one cycle later.

While both ports are enabled on the same address, the block grants the location to the port that arrived first and flags busy to the other port. A write from the flagged port is dropped. The flagged port also keeps its previous read data while the owner may be changing the location. When the mode pin selects slave operation, the block does no arbitration of its own. It takes the busy pins of a master copy as inputs, so several copies can be ganged side by side for wider words with one common decision.

The read path is a plain stream with valid and no ready. A port that wants data holds its inputs, and the data is there one cycle later. The block cannot stall, so no back-pressure exists.

Top module: `twin_port_ram`

## Requirements
- R1: A read returns the byte last written to that address, one cycle after the read is sampled. If the other port writes the same address at the same edge, the read returns the value from before that write.
- R2: In master mode (mode pin low), a busy output goes low only if both ports were enabled with equal addresses at the previous edge. The two busy outputs are never low together.
- R3: When a collision starts, a port that was already enabled at the same address on the previous edge wins, and the other port is flagged busy. The winner keeps ownership for as long as the collision lasts.
- R4: When both ports reach the common address at the same edge, with neither one already there, the left port wins and the right port is flagged.
- R5: In master mode, both busy outputs are high in the cycle after an edge where the addresses differ or either enable is high.
- R6: A port writes only when its enable and write select are both low at the edge. A write from a port that is flagged at that edge is dropped. If both ports write the same address in slave mode, the left data is stored.
- R7: In slave mode (mode pin high), each busy output repeats its busy input one cycle late. A write from a port whose busy input is low is dropped.
- R8: A flagged port that reads keeps its previous read data. It reloads when it is no longer flagged, or on an edge where its address changed, its enable fell, or its write select rose.
- R9: Read-valid is high in the cycle after an edge where the port was enabled, in read mode (write select high) and had output enable low. Otherwise it is low.
- R10: After reset, both busy outputs are high and both read-valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_sel | input | 1 | 1: busy pins are inputs from a master; 0: local arbitration |
| lt_ce_n | input | 1 | Left enable, active low |
| lt_wr_n | input | 1 | Left write select, 0 = write, 1 = read |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_addr | input | 11 | Left address |
| lt_wdata | input | 8 | Left write data |
| lt_busy_in_n | input | 1 | Left busy from master (slave mode only) |
| lt_busy_n | output | 1 | Left busy flag, active low, registered |
| lt_rdata | output | 8 | Left read data |
| lt_rvalid | output | 1 | Left read data valid |
| rt_ce_n | input | 1 | Right enable, active low |
| rt_wr_n | input | 1 | Right write select, 0 = write, 1 = read |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_addr | input | 11 | Right address |
| rt_wdata | input | 8 | Right write data |
| rt_busy_in_n | input | 1 | Right busy from master (slave mode only) |
| rt_busy_n | output | 1 | Right busy flag, active low, registered |
| rt_rdata | output | 8 | Right read data |
| rt_rvalid | output | 1 | Right read data valid |

## Verification
A wrong ownership record shows up one cycle after the edge that decides it. The wrong busy pin goes low, or busy stays low after the addresses part. The harm can also stay hidden: a dropped write that should have landed, or a landed write that should have been dropped, only shows when a later read of that address returns the wrong byte. For this reason the bench checks every read against a shadow copy of the memory, and it keeps reading a small set of contested addresses. A bad hold-or-reload choice shows as stale or early read data in the cycle right after the edge in question.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/tpr_port_track.sv
// Remembers last-edge port state; flags edges where a held read must reload.
module tpr_port_track #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          prev_en,
  output logic [AW-1:0] prev_addr,
  output logic          fresh
);
  logic prev_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_wr_n <= 1'b1;
      prev_addr <= '0;
    end else begin
      prev_en   <= !ce_n;
      prev_wr_n <= wr_n;
      prev_addr <= addr;
    end
  end

  // address moved, enable just fell, or write select just rose
  assign fresh = (addr != prev_addr) || (!prev_en && !ce_n) || (!prev_wr_n && wr_n);
endmodule

// File: rtl/tpr_arbiter.sv
module tpr_arbiter
  import tpr_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_sel,
  input  logic          l_en,
  input  logic          r_en,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  input  logic          l_prev_en,
  input  logic [AW-1:0] l_prev_addr,
  input  logic          r_prev_en,
  input  logic [AW-1:0] r_prev_addr,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_blk,
  output logic          r_blk,
  output logic          l_busy_n,
  output logic          r_busy_n
);
  owner_e owner_q, owner_d;
  logic   hit, l_early, r_early;

  assign hit     = l_en && r_en && (l_addr == r_addr);
  assign l_early = l_prev_en && (l_prev_addr == l_addr);
  assign r_early = r_prev_en && (r_prev_addr == r_addr);

  always_comb begin
    owner_d = owner_q;
    if (!hit)                   owner_d = OWN_NONE;
    else if (owner_q == OWN_NONE)
      owner_d = (r_early && !l_early) ? OWN_RIGHT : OWN_LEFT;
  end

  always_comb begin
    if (slave_sel) begin
      l_blk = !l_busy_in_n;
      r_blk = !r_busy_in_n;
    end else begin
      l_blk = (owner_d == OWN_RIGHT);
      r_blk = (owner_d == OWN_LEFT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_busy_n <= 1'b1;
      r_busy_n <= 1'b1;
    end else begin
      owner_q  <= owner_d;
      l_busy_n <= !l_blk;
      r_busy_n <= !r_blk;
    end
  end

  // R2
  busy_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!slave_sel) && (!l_busy_n || !r_busy_n)) |-> $past(hit));
  // R2
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!slave_sel) |-> (l_busy_n || r_busy_n));
  // R3
  owner_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel && $past(!slave_sel) && !r_busy_n && hit) |=> !r_busy_n);
  // R7
  slave_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_sel && !l_busy_in_n) |=> !l_busy_n);
endmodule

// File: rtl/tpr_storage.sv
module tpr_storage #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int NP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0][AW-1:0]  addr,
  input  logic [NP-1:0]          wr_go,
  input  logic [NP-1:0][DW-1:0]  wdata,
  input  logic [NP-1:0]          rd_load,
  input  logic [NP-1:0]          rd_vis,
  output logic [NP-1:0][DW-1:0]  rdata,
  output logic [NP-1:0]          rvalid
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // highest index first, so port 0 lands last and wins a same-address tie
  always_ff @(posedge clk) begin
    for (int p = NP - 1; p >= 0; p--) begin
      if (wr_go[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[g]  <= '0;
        rvalid[g] <= 1'b0;
      end else begin
        if (rd_load[g]) rdata[g] <= mem[addr[g]];
        rvalid[g] <= rd_vis[g];
      end
    end
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_sel,
  input  logic          lt_ce_n,
  input  logic          lt_wr_n,
  input  logic          lt_oe_n,
  input  logic [AW-1:0] lt_addr,
  input  logic [DW-1:0] lt_wdata,
  input  logic          lt_busy_in_n,
  output logic          lt_busy_n,
  output logic [DW-1:0] lt_rdata,
  output logic          lt_rvalid,
  input  logic          rt_ce_n,
  input  logic          rt_wr_n,
  input  logic          rt_oe_n,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rt_wdata,
  input  logic          rt_busy_in_n,
  output logic          rt_busy_n,
  output logic [DW-1:0] rt_rdata,
  output logic          rt_rvalid
);
  localparam int NP = 2;

  logic [NP-1:0]         ce_n, wr_n, oe_n, prev_en, fresh, blk;
  logic [NP-1:0][AW-1:0] addr, prev_addr;
  logic [NP-1:0][DW-1:0] wdata, rdata;
  logic [NP-1:0]         wr_go, rd_load, rd_vis, rvalid;

  assign ce_n  = {rt_ce_n, lt_ce_n};
  assign wr_n  = {rt_wr_n, lt_wr_n};
  assign oe_n  = {rt_oe_n, lt_oe_n};
  assign addr  = {rt_addr, lt_addr};
  assign wdata = {rt_wdata, lt_wdata};

  for (genvar g = 0; g < NP; g++) begin : g_port
    tpr_port_track #(.AW(AW)) u_trk (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n[g]), .wr_n(wr_n[g]), .addr(addr[g]),
      .prev_en(prev_en[g]), .prev_addr(prev_addr[g]), .fresh(fresh[g])
    );
    assign wr_go[g]   = !ce_n[g] && !wr_n[g] && !blk[g];
    assign rd_load[g] = !ce_n[g] && wr_n[g] && (!blk[g] || fresh[g]);
    assign rd_vis[g]  = !ce_n[g] && wr_n[g] && !oe_n[g];
  end

  tpr_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .slave_sel(slave_sel),
    .l_en(!lt_ce_n), .r_en(!rt_ce_n), .l_addr(lt_addr), .r_addr(rt_addr),
    .l_prev_en(prev_en[0]), .l_prev_addr(prev_addr[0]),
    .r_prev_en(prev_en[1]), .r_prev_addr(prev_addr[1]),
    .l_busy_in_n(lt_busy_in_n), .r_busy_in_n(rt_busy_in_n),
    .l_blk(blk[0]), .r_blk(blk[1]), .l_busy_n(lt_busy_n), .r_busy_n(rt_busy_n)
  );

  tpr_storage #(.AW(AW), .DW(DW), .NP(NP)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_go(wr_go), .wdata(wdata),
    .rd_load(rd_load), .rd_vis(rd_vis), .rdata(rdata), .rvalid(rvalid)
  );

  assign lt_rdata  = rdata[0];
  assign rt_rdata  = rdata[1];
  assign lt_rvalid = rvalid[0];
  assign rt_rvalid = rvalid[1];

  // R5
  release_on_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_sel && (lt_ce_n || rt_ce_n || lt_addr != rt_addr)) |=> (lt_busy_n && rt_busy_n));
  // R9
  lt_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_rvalid |-> $past(!lt_ce_n && lt_wr_n && !lt_oe_n));
  // R9
  rt_valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_rvalid |-> $past(!rt_ce_n && rt_wr_n && !rt_oe_n));
endmodule

// File: tb/twin_port_ram_test.sv
module twin_port_ram_test;
  logic clk = 1'b0, rst_n = 1'b0, slave_sel = 1'b0;
  logic lt_ce_n = 1, lt_wr_n = 1, lt_oe_n = 1, lt_busy_in_n = 1;
  logic rt_ce_n = 1, rt_wr_n = 1, rt_oe_n = 1, rt_busy_in_n = 1;
  logic [10:0] lt_addr = 0, rt_addr = 0;
  logic [7:0]  lt_wdata = 0, rt_wdata = 0;
  logic lt_busy_n, rt_busy_n, lt_rvalid, rt_rvalid;
  logic [7:0] lt_rdata, rt_rdata;

  always #10 clk = ~clk;

  twin_port_ram uut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // shadow model
  logic [7:0]  sm [2048];
  int          own = 0;           // 0 none, 1 left owns, 2 right owns
  bit          e_lb = 1, e_rb = 1, e_lv = 0, e_rv = 0;
  logic [7:0]  e_ld = 0, e_rd = 0;
  bit          p_len = 0, p_ren = 0, p_lwn = 1, p_rwn = 1;
  logic [10:0] p_la = 0, p_ra = 0;

  function automatic bit is_fresh(bit pen, bit pwn, logic [10:0] pa, bit ce_n, bit wn, logic [10:0] a);
    return (a != pa) || (!pen && !ce_n) || (!pwn && wn);
  endfunction

  function automatic void model_edge();
    bit len = !lt_ce_n, ren = !rt_ce_n;
    bit hit = len && ren && (lt_addr == rt_addr);
    bit le = p_len && (p_la == lt_addr), re = p_ren && (p_ra == rt_addr);
    bit lb, rb;
    logic [7:0] ol = sm[lt_addr], orr = sm[rt_addr];
    if (!hit) own = 0;
    else if (own == 0) own = (re && !le) ? 2 : 1;
    if (slave_sel) begin lb = !lt_busy_in_n; rb = !rt_busy_in_n; end
    else begin lb = (own == 2); rb = (own == 1); end
    if (len && lt_wr_n && (!lb || is_fresh(p_len, p_lwn, p_la, lt_ce_n, lt_wr_n, lt_addr))) e_ld = ol;
    if (ren && rt_wr_n && (!rb || is_fresh(p_ren, p_rwn, p_ra, rt_ce_n, rt_wr_n, rt_addr))) e_rd = orr;
    e_lv = len && lt_wr_n && !lt_oe_n;
    e_rv = ren && rt_wr_n && !rt_oe_n;
    if (ren && !rt_wr_n && !rb) sm[rt_addr] = rt_wdata;
    if (len && !lt_wr_n && !lb) sm[lt_addr] = lt_wdata;
    e_lb = !lb; e_rb = !rb;
    p_len = len; p_ren = ren; p_lwn = lt_wr_n; p_rwn = rt_wr_n; p_la = lt_addr; p_ra = rt_addr;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk); #1 model_edge();
    @(negedge clk);
    chk(tag, "lt_busy_n", lt_busy_n, e_lb);
    chk(tag, "rt_busy_n", rt_busy_n, e_rb);
    chk(tag, "lt_rvalid", lt_rvalid, e_lv);
    chk(tag, "rt_rvalid", rt_rvalid, e_rv);
    if (e_lv) chk(tag, "lt_rdata", lt_rdata, e_ld);
    if (e_rv) chk(tag, "rt_rdata", rt_rdata, e_rd);
  endtask

  task automatic drv(bit lce, bit lwr, bit loe, logic [10:0] la, logic [7:0] ld,
                     bit rce, bit rwr, bit roe, logic [10:0] ra, logic [7:0] rd);
    lt_ce_n = lce; lt_wr_n = lwr; lt_oe_n = loe; lt_addr = la; lt_wdata = ld;
    rt_ce_n = rce; rt_wr_n = rwr; rt_oe_n = roe; rt_addr = ra; rt_wdata = rd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  localparam logic [10:0] A0 = 11'h7FF, A1 = 11'h7FE, A2 = 11'h000, A3 = 11'h155;
  logic [10:0] aset [4] = '{A0, A1, A2, A3};

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 2048; i++) sm[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "lt_busy_n", lt_busy_n, 1);
    chk("R10", "rt_busy_n", rt_busy_n, 1);
    chk("R10", "lt_rvalid", lt_rvalid, 0);
    chk("R10", "rt_rvalid", rt_rvalid, 0);
    rst_n = 1;
    // R1 fill the contested addresses, then read them back from both sides
    for (int i = 0; i < 4; i++) begin
      drv(0, 0, 1, aset[i], 8'h10 + 8'(i), 1, 1, 1, 0, 0); step("R1");
    end
    for (int i = 0; i < 4; i++) begin
      drv(0, 1, 0, aset[i], 0, 0, 1, 0, aset[3 - i], 0); step("R1");
    end
    chk("R1", "lt_rdata literal", lt_rdata, 8'h13);
    // R6 write with enable high does nothing
    drv(1, 0, 1, A0, 8'hEE, 1, 1, 1, 0, 0); step("R6");
    drv(0, 1, 0, A0, 0, 1, 1, 1, 0, 0); step("R6");
    chk("R6", "ce-high write ignored", lt_rdata, 8'h10);
    drv(1, 1, 1, 0, 0, 1, 1, 1, 0, 0); step("R5");
    // R3 left first, right joins and tries to write: flagged, write dropped
    drv(0, 1, 0, A1, 0, 1, 1, 1, 0, 0); step("R3");
    drv(0, 1, 0, A1, 0, 0, 0, 1, A1, 8'hBB); step("R3");
    chk("R3", "rt_busy_n literal", rt_busy_n, 0);
    drv(0, 1, 0, A1, 0, 0, 0, 1, A1, 8'hBC); step("R6");
    chk("R6", "lt_rdata after dropped write", lt_rdata, 8'h11);
    // R5 right moves away: released
    drv(0, 1, 0, A1, 0, 0, 1, 0, A2, 0); step("R5");
    chk("R5", "rt_busy_n literal", rt_busy_n, 1);
    // R3 right first at A2, left joins
    drv(1, 1, 1, 0, 0, 0, 1, 0, A2, 0); step("R3");
    drv(0, 1, 0, A2, 0, 0, 1, 0, A2, 0); step("R3");
    chk("R3", "lt_busy_n literal", lt_busy_n, 0);
    // R5 release by enable high
    drv(0, 1, 0, A2, 0, 1, 1, 0, A2, 0); step("R5");
    // R4 simultaneous arrival, left wins
    drv(1, 1, 1, 0, 0, 1, 1, 1, 0, 0); step("R4");
    drv(0, 1, 0, A3, 0, 0, 1, 0, A3, 0); step("R4");
    chk("R4", "rt_busy_n literal", rt_busy_n, 0);
    // R8 right flagged reader holds while left writes, reloads once free
    drv(0, 0, 1, A3, 8'h77, 0, 1, 0, A3, 0); step("R8");
    chk("R8", "rt_rdata held", rt_rdata, 8'h13);
    drv(0, 1, 0, A0, 0, 0, 1, 0, A3, 0); step("R8");
    chk("R8", "rt_rdata reloaded", rt_rdata, 8'h77);
    // R9 output enable high hides data
    drv(0, 1, 1, A0, 0, 0, 0, 0, A2, 8'h22); step("R9");
    chk("R9", "lt_rvalid literal", lt_rvalid, 0);
    // R7 slave mode: busy from inputs, blocked write dropped
    slave_sel = 1; lt_busy_in_n = 0; rt_busy_in_n = 1;
    drv(0, 0, 1, A0, 8'h99, 1, 1, 1, 0, 0); step("R7");
    chk("R7", "lt_busy_n literal", lt_busy_n, 0);
    lt_busy_in_n = 1;
    drv(0, 1, 0, A0, 0, 1, 1, 1, 0, 0); step("R7");
    chk("R7", "slave dropped write", lt_rdata, 8'h10);
    // R6 slave same-address double write: left stored
    drv(0, 0, 1, A2, 8'hA1, 0, 0, 1, A2, 8'hB2); step("R6");
    drv(0, 1, 0, A2, 0, 1, 1, 1, 0, 0); step("R6");
    chk("R6", "left wins tie", lt_rdata, 8'hA1);
    slave_sel = 0;
    // random mix over the contested addresses
    for (int c = 0; c < 4000; c++) begin
      slave_sel = (c >= 2500);
      lt_busy_in_n = ($urandom % 4) != 0;
      rt_busy_in_n = ($urandom % 4) != 0;
      drv(($urandom % 5) == 0, ($urandom % 3) != 0, ($urandom % 5) == 0, aset[$urandom % 4], 8'($urandom),
          ($urandom % 5) == 0, ($urandom % 3) != 0, ($urandom % 5) == 0, aset[$urandom % 4], 8'($urandom));
      step((c % 2) ? "R2" : "R8");
    end
    finish_run();
  end
endmodule